// File: doc/BRIEF.md
# Serial Master Frame Engine with Chip-Select Timing

This block is a synchronous serial master. It drives a serial clock, a data-out line and a chip-select line, and it samples a data-in line. A single-cycle `start_i` latches a full set of per-transfer settings together with a 32-bit transmit word. The block then runs one frame through a fixed sequence: chip-select assertion, a clock-start delay, the shifting phase, a negation delay, and a wait before chip-select may assert again.

Clock polarity, clock phase, bit order, chip-select polarity, the level on the data-out line while chip-select is inactive, the frame length, the clock divider and the three timing gaps are all chosen for each transfer. In full-duplex mode the received word appears on `rx_data_o`, right-aligned. `done_o` pulses when the frame has fully closed. While the block is idle, the idle levels of the serial clock, chip-select and data-out follow the live configuration inputs. During a transfer they follow the values latched at start.

Top module: `spi_frame_master`

## Requirements
- R1: `len_code_i` selects the frame length. Codes 0 to 8 select 8 to 16 bits, code 9 selects 20 bits, code 10 selects 24 bits and code 11 selects 32 bits. Codes 12 to 15 select 8 bits. A frame of N bits produces exactly 2N serial-clock edges while chip-select is active.
- R2: The serial clock rests at `cpol_i`. With `cpha_i`=0, data-in is sampled on leading edges and data-out changes on trailing edges. With `cpha_i`=1, data-out changes on leading edges after the first one, and data-in is sampled on trailing edges.
- R3: With `lsb_first_i`=1, bit 0 of the transmit word goes out first. With `lsb_first_i`=0, bit N-1 goes out first. The received word uses the same order and is right-aligned in `rx_data_o`, with the upper bits zero.
- R4: From chip-select assertion to the first serial-clock edge there are exactly 2·(`lead_i`+1)·(`div_i`+1) system cycles.
- R5: From the last serial-clock edge to chip-select negation there are exactly 2·(`lag_i`+1)·(`div_i`+1) system cycles.
- R6: After negation, `busy_o` stays high for 2·(`gap_i`+1)·(`div_i`+1) system cycles. With `start_i` held high, chip-select reasserts one system cycle after that wait ends. A `start_i` or `tx_data_i` change while `busy_o` is high does not affect the frame in progress.
- R7: Each half-period of the serial clock is `div_i`+1 system cycles, so the division ratio is 2·(`div_i`+1), from 2 to 4096.
- R8: Chip-select is active at the level of `cs_pol_i` (1 = active high) and rests at its inverse. While chip-select is inactive, data-out equals `idle_mosi_i`.
- R9: With `tx_only_i`=1, data-in is ignored and `rx_data_o` reads zero after the frame.
- R10: `done_o` is high for exactly one system cycle per frame, in the same cycle that chip-select negates. `rx_data_o` holds the received word from that cycle onward.
- R11: In reset the block is idle: `busy_o`=0, `done_o`=0, `rx_data_o`=0, and the outputs show the idle levels from R2 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame when idle |
| cpol_i | input | 1 | Serial-clock rest level |
| cpha_i | input | 1 | Sampling phase select |
| lsb_first_i | input | 1 | 1 = LSB first |
| tx_only_i | input | 1 | 1 = ignore data-in |
| cs_pol_i | input | 1 | Chip-select active level |
| idle_mosi_i | input | 1 | Data-out level while chip-select is inactive |
| len_code_i | input | 4 | Frame length code |
| div_i | input | 11 | Half-period minus one, in system cycles |
| lead_i | input | 3 | Clock-start delay code |
| lag_i | input | 3 | Negation delay code |
| gap_i | input | 3 | Next-access wait code |
| tx_data_i | input | 32 | Transmit word, right-aligned |
| miso_i | input | 1 | Serial data in |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| cs_o | output | 1 | Chip select |
| busy_o | output | 1 | Frame or wait in progress |
| rx_data_o | output | 32 | Received word, right-aligned |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
Two events are designed to share a cycle: the completion strobe, and chip-select negation with the received-word update. The bench timestamps both events at the pins on every frame and requires the two stamps to be equal. A second coincidence comes from holding `start_i` high through a whole frame while `tx_data_i` changes mid-frame. The request is then present in the same cycle the post-negation wait ends. The bench judges this case by the measured reassertion gap and by comparing the first frame's wire bits with the original word.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_XFER,
    ST_LAG,
    ST_GAP
  } seq_state_e;

  // length code -> bits per frame; unused codes fall back to 8
  function automatic logic [5:0] frame_len(input logic [3:0] code);
    logic [5:0] n;
    if (code <= 4'd8)       n = 6'd8 + {2'b00, code};
    else if (code == 4'd9)  n = 6'd20;
    else if (code == 4'd10) n = 6'd24;
    else if (code == 4'd11) n = 6'd32;
    else                    n = 6'd8;
    return n;
  endfunction

endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int DIV_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = $clog2(DATA_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              lsb_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              miso_i,
  output logic              mosi_bit_o,
  output logic [DATA_W-1:0] rx_word_o
);

  logic [DATA_W-1:0] tx_sr_q, rx_sr_q;
  logic [LEN_W-1:0]  len_q;
  logic              lsb_q;

  assign mosi_bit_o = lsb_q ? tx_sr_q[0] : tx_sr_q[DATA_W-1];
  // lsb-first bits enter at the top; realign to bit 0
  assign rx_word_o  = lsb_q ? (rx_sr_q >> (DATA_W - int'(len_q))) : rx_sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr_q <= '0;
      rx_sr_q <= '0;
      len_q   <= LEN_W'(8);
      lsb_q   <= 1'b0;
    end else if (load_i) begin
      tx_sr_q <= lsb_i ? tx_data_i : (tx_data_i << (DATA_W - int'(len_i)));
      rx_sr_q <= '0;
      len_q   <= len_i;
      lsb_q   <= lsb_i;
    end else begin
      if (shift_i)
        tx_sr_q <= lsb_q ? (tx_sr_q >> 1) : (tx_sr_q << 1);
      if (sample_i)
        rx_sr_q <= lsb_q ? {miso_i, rx_sr_q[DATA_W-1:1]} : {rx_sr_q[DATA_W-2:0], miso_i};
    end
  end

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spi_frame_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 11,
  parameter int DLY_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              lsb_first_i,
  input  logic              tx_only_i,
  input  logic              cs_pol_i,
  input  logic              idle_mosi_i,
  input  logic [3:0]        len_code_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [DLY_W-1:0]  lead_i,
  input  logic [DLY_W-1:0]  lag_i,
  input  logic [DLY_W-1:0]  gap_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              cs_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              done_o
);

  localparam int LEN_W  = $clog2(DATA_W) + 1;
  localparam int ECNT_W = LEN_W + 1;

  seq_state_e        state_q;
  logic [ECNT_W-1:0] ecnt_q;
  logic              tog_q, done_q;
  logic [DATA_W-1:0] rx_q;
  logic              cpol_q, cpha_q, txo_q, cspol_q, idle_q;
  logic [DIV_W-1:0]  div_q;
  logic [DLY_W-1:0]  lead_q, lag_q, gap_q;
  logic [LEN_W-1:0]  len_q, len_new;

  logic baud_tick, accept, is_idle, cs_act, xfer_edge;
  logic shift_en, sample_en, tx_bit;
  logic [DATA_W-1:0] rx_word;

  assign len_new   = LEN_W'(frame_len(len_code_i));
  assign is_idle   = (state_q == ST_IDLE);
  assign accept    = is_idle && start_i;
  assign cs_act    = (state_q == ST_LEAD) || (state_q == ST_XFER) || (state_q == ST_LAG);
  assign xfer_edge = (state_q == ST_XFER) && baud_tick;
  assign shift_en  = xfer_edge && (ecnt_q[0] != cpha_q) && (ecnt_q != '0);
  assign sample_en = xfer_edge && (ecnt_q[0] == cpha_q) && !txo_q;

  spi_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (!is_idle),
    .div_i  (div_q),
    .tick_o (baud_tick)
  );

  spi_shift_unit #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .tx_data_i  (tx_data_i),
    .len_i      (len_new),
    .lsb_i      (lsb_first_i),
    .shift_i    (shift_en),
    .sample_i   (sample_en),
    .miso_i     (miso_i),
    .mosi_bit_o (tx_bit),
    .rx_word_o  (rx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ecnt_q  <= '0;
      tog_q   <= 1'b0;
      done_q  <= 1'b0;
      rx_q    <= '0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      txo_q   <= 1'b0;
      cspol_q <= 1'b0;
      idle_q  <= 1'b0;
      div_q   <= '0;
      lead_q  <= '0;
      lag_q   <= '0;
      gap_q   <= '0;
      len_q   <= LEN_W'(8);
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          cpol_q  <= cpol_i;
          cpha_q  <= cpha_i;
          txo_q   <= tx_only_i;
          cspol_q <= cs_pol_i;
          idle_q  <= idle_mosi_i;
          div_q   <= div_i;
          lead_q  <= lead_i;
          lag_q   <= lag_i;
          gap_q   <= gap_i;
          len_q   <= len_new;
          ecnt_q  <= '0;
          tog_q   <= 1'b0;
          state_q <= ST_LEAD;
        end
        // leave one tick early: the entry tick into XFER is edge 0
        ST_LEAD: if (baud_tick) begin
          if (ecnt_q == ECNT_W'(2 * lead_q)) begin
            ecnt_q  <= '0;
            state_q <= ST_XFER;
          end else ecnt_q <= ecnt_q + 1'b1;
        end
        ST_XFER: if (baud_tick) begin
          tog_q <= ~tog_q;
          if (ecnt_q == ECNT_W'(2 * len_q - 1)) begin
            ecnt_q  <= '0;
            state_q <= ST_LAG;
          end else ecnt_q <= ecnt_q + 1'b1;
        end
        ST_LAG: if (baud_tick) begin
          if (ecnt_q == ECNT_W'(2 * lag_q + 1)) begin
            ecnt_q  <= '0;
            done_q  <= 1'b1;
            rx_q    <= rx_word;
            state_q <= ST_GAP;
          end else ecnt_q <= ecnt_q + 1'b1;
        end
        ST_GAP: if (baud_tick) begin
          if (ecnt_q == ECNT_W'(2 * gap_q + 1)) begin
            ecnt_q  <= '0;
            state_q <= ST_IDLE;
          end else ecnt_q <= ecnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = !is_idle;
  assign done_o    = done_q;
  assign rx_data_o = rx_q;
  assign sclk_o    = is_idle ? cpol_i : (cpol_q ^ tog_q);
  assign cs_o      = is_idle ? ~cs_pol_i : (cs_act ? cspol_q : ~cspol_q);
  assign mosi_o    = is_idle ? idle_mosi_i : (cs_act ? tx_bit : idle_q);

endmodule

// File: rtl/spi_frame_master_chk.sv
module spi_frame_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_i,
  input logic done_i,
  input logic cs_i,
  input logic sclk_i,
  input logic tick_i
);

  // R10
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R10
  done_with_negate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (cs_i != $past(cs_i)));

  // R7
  sclk_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i) && (sclk_i != $past(sclk_i))) |-> $past(tick_i));

  // R4
  cs_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i) && (cs_i != $past(cs_i))) |-> $past(tick_i));

  // R10
  done_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> busy_i);

endmodule

bind spi_frame_master spi_frame_master_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy_i (busy_o),
  .done_i (done_o),
  .cs_i   (cs_o),
  .sclk_i (sclk_o),
  .tick_i (baud_tick)
);

// File: tb/spi_frame_master_tb.sv
module spi_frame_master_tb;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic        cfg_cpol = 0, cfg_cpha = 0, cfg_lsb = 0, cfg_txo = 0;
  logic        cfg_cspol = 0, cfg_idle = 0, start_r = 0, miso_r = 0;
  logic [3:0]  cfg_code = 0;
  logic [10:0] cfg_div = 0;
  logic [2:0]  cfg_lead = 0, cfg_lag = 0, cfg_gap = 0;
  logic [31:0] tx_r = 0, slv = 0;

  logic        sclk_o, mosi_o, cs_o, busy_o, done_o;
  logic [31:0] rx_data_o;

  spi_frame_master u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_r),
    .cpol_i(cfg_cpol), .cpha_i(cfg_cpha), .lsb_first_i(cfg_lsb),
    .tx_only_i(cfg_txo), .cs_pol_i(cfg_cspol), .idle_mosi_i(cfg_idle),
    .len_code_i(cfg_code), .div_i(cfg_div), .lead_i(cfg_lead),
    .lag_i(cfg_lag), .gap_i(cfg_gap), .tx_data_i(tx_r), .miso_i(miso_r),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .cs_o(cs_o), .busy_o(busy_o),
    .rx_data_o(rx_data_o), .done_o(done_o)
  );

  int checks = 0, failures = 0;

  function automatic int exp_len(input logic [3:0] c);
    case (c)
      4'd9:    return 20;
      4'd10:   return 24;
      4'd11:   return 32;
      default: return (c <= 4'd8) ? 8 + int'(c) : 8;
    endcase
  endfunction

  function automatic logic [31:0] mask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // pin monitor and serial peripheral model
  int cyc = 0, t_on = 0, t_first = 0, t_last = 0, t_off = 0, t_prev = 0;
  int edges = 0, lead_n = 0, trail_n = 0, nbits = 0, bad_per = 0, idle_bad = 0;
  int done_cnt = 0, t_done = 0, done_edges = 0, done_badper = 0, gap_meas = 0;
  logic prev_act = 0, prev_sclk = 0;
  logic [31:0] mon_word = 0, done_word = 0, done_rx = 0;

  always @(negedge clk_i) begin
    logic act, lead_e, samp;
    int idx, n;
    cyc++;
    n = exp_len(cfg_code);
    act = rst_ni && (cs_o == cfg_cspol);
    if (rst_ni) begin
      if (act && !prev_act) begin
        gap_meas = cyc - t_off; t_on = cyc;
        edges = 0; lead_n = 0; trail_n = 0; nbits = 0; bad_per = 0; mon_word = 0;
      end
      if (!act && prev_act) t_off = cyc;
      if (!act && mosi_o !== cfg_idle) idle_bad++;
      if (act && sclk_o != prev_sclk) begin
        if (edges == 0) t_first = cyc;
        else if (cyc - t_prev != int'(cfg_div) + 1) bad_per++;
        t_prev = cyc; t_last = cyc; edges++;
        lead_e = (sclk_o != cfg_cpol);
        samp = (lead_e != cfg_cpha);
        if (samp) begin
          if (cfg_lsb) mon_word[nbits] = mosi_o;
          else mon_word = {mon_word[30:0], mosi_o};
          nbits++;
        end
        if (lead_e) lead_n++; else trail_n++;
      end
      if (done_o) begin
        done_cnt++; t_done = cyc; done_word = mon_word; done_rx = rx_data_o;
        done_edges = edges; done_badper = bad_per;
      end
      idx = cfg_cpha ? ((lead_n == 0) ? 0 : lead_n - 1) : trail_n;
      if (idx < n) miso_r <= cfg_lsb ? slv[idx] : slv[n-1-idx];
      else miso_r <= 1'b0;
    end
    prev_act = act;
    prev_sclk = sclk_o;
  end

  task automatic wait_done(input int d0);
    for (int i = 0; i < 100000 && done_cnt == d0; i++) @(negedge clk_i);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100000 && busy_o; i++) @(negedge clk_i);
  endtask

  task automatic do_frame();
    int d0;
    d0 = done_cnt;
    idle_bad = 0;
    @(negedge clk_i); start_r = 1;
    @(negedge clk_i); start_r = 0;
    wait_done(d0);
    chk("R10 one done", done_cnt, d0 + 1);
    wait_idle();
  endtask

  task automatic check_frame(input string tag);
    int n, p;
    n = exp_len(cfg_code);
    p = int'(cfg_div) + 1;
    chk({tag, " R3 tx wire word"}, done_word & mask(n), tx_r & mask(n));
    chk({tag, " R9/R3 rx word"}, done_rx, cfg_txo ? 32'h0 : (slv & mask(n)));
    chk({tag, " R1 edge count"}, done_edges, 2 * n);
    chk({tag, " R7 half period"}, done_badper, 0);
    chk({tag, " R4 lead"}, t_first - t_on, 2 * (int'(cfg_lead) + 1) * p);
    chk({tag, " R5 lag"}, t_off - t_last, 2 * (int'(cfg_lag) + 1) * p);
    chk({tag, " R10 done at negation"}, t_done, t_off);
    chk({tag, " R8 idle mosi"}, idle_bad, 0);
  endtask

  task automatic t_reset();
    chk("R11 cs idle", cs_o, 1);
    chk("R11 sclk idle", sclk_o, 0);
    chk("R11 busy", busy_o, 0);
    chk("R11 done", done_o, 0);
    chk("R11 rx", rx_data_o, 0);
    chk("R11 mosi idle", mosi_o, 0);
  endtask

  task automatic t_modes();
    for (int m = 0; m < 4; m++) begin
      cfg_cpol = m[1]; cfg_cpha = m[0]; cfg_lsb = 0; cfg_code = 0; cfg_div = 1;
      tx_r = 32'hA5 ^ m; slv = 32'h3C + m;
      do_frame();
      check_frame("R2 mode");
      chk("R2 sclk rest", sclk_o, cfg_cpol);
    end
  endtask

  task automatic t_lengths();
    logic [3:0] codes [5] = '{4'd9, 4'd10, 4'd11, 4'd1, 4'd8};
    for (int i = 0; i < 5; i++) begin
      cfg_cpol = i[0]; cfg_cpha = i[1]; cfg_lsb = (i != 4); cfg_code = codes[i];
      cfg_div = 0; tx_r = 32'h9E37_79B9 + i; slv = 32'h6A09_E667 ^ (i * 1234567);
      do_frame();
      check_frame("R1 R3 length");
    end
  endtask

  task automatic t_txonly();
    cfg_txo = 1; cfg_code = 4'd10; cfg_lsb = 0; cfg_div = 2; cfg_cpha = 1;
    tx_r = 32'h00C3_5A7E; slv = 32'hFFFF_FFFF;
    do_frame();
    check_frame("R9 tx-only");
    chk("R9 rx zero", rx_data_o, 0);
    cfg_txo = 0;
  endtask

  task automatic t_delays();
    cfg_code = 4'd3; cfg_div = 2; cfg_lead = 7; cfg_lag = 3; cfg_gap = 2;
    cfg_cpol = 0; cfg_cpha = 0; tx_r = 32'h5AB; slv = 32'h4D2;
    do_frame();
    check_frame("R4 R5 delays");
    cfg_lead = 0; cfg_lag = 0; cfg_gap = 0;
  endtask

  task automatic t_div_max();
    cfg_code = 0; cfg_div = 11'd2047; tx_r = 32'h81; slv = 32'h7E;
    do_frame();
    check_frame("R7 max divide");
    cfg_div = 1;
  endtask

  task automatic t_cspol();
    cfg_cspol = 1; cfg_idle = 1;
    @(negedge clk_i);
    chk("R8 cs rest low", cs_o, 0);
    chk("R8 mosi idle high", mosi_o, 1);
    cfg_code = 4'd7; tx_r = 32'h7FFE; slv = 32'h1234;
    do_frame();
    check_frame("R8 cs active high");
    chk("R8 mosi after frame", mosi_o, 1);
    cfg_cspol = 0; cfg_idle = 0;
    @(negedge clk_i);
  endtask

  task automatic t_bad_code();
    cfg_code = 4'd13; cfg_lsb = 1; tx_r = 32'hFFFF_FF96; slv = 32'hAAAA_AA69;
    do_frame();
    check_frame("R1 unused code");
    cfg_lsb = 0;
  endtask

  task automatic t_back_to_back();
    int d0, p;
    logic [31:0] w1;
    cfg_code = 0; cfg_div = 1; cfg_gap = 5; cfg_lead = 1; cfg_lag = 1;
    tx_r = 32'h3C; slv = 32'h99;
    p = int'(cfg_div) + 1;
    d0 = done_cnt;
    @(negedge clk_i); start_r = 1;
    for (int i = 0; i < 1000 && !busy_o; i++) @(negedge clk_i);
    repeat (20) @(negedge clk_i);
    tx_r = 32'hC3;  // mid-frame change, start still high
    wait_done(d0);
    w1 = done_word;
    chk("R6 first frame keeps word", w1 & 32'hFF, 32'h3C);
    wait_idle();
    for (int i = 0; i < 10 && !busy_o; i++) @(negedge clk_i);
    start_r = 0;
    wait_done(d0 + 1);
    chk("R6 gap length", gap_meas, 2 * (int'(cfg_gap) + 1) * p + 1);
    chk("R6 second frame word", done_word & 32'hFF, 32'hC3);
    chk("R10 second done", done_cnt, d0 + 2);
    wait_idle();
    cfg_gap = 0; cfg_lead = 0; cfg_lag = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_modes();
    t_lengths();
    t_txonly();
    t_delays();
    t_cspol();
    t_bad_code();
    t_back_to_back();
    t_div_max();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule